// File: doc/BRIEF.md
# Memory-Mapped 16-Bit Periodic Reload Timer

This peripheral counts down a 16-bit value at a fixed 1 MHz rate and restarts from a programmed period each time the count has been exhausted. The 1 MHz tick comes from a prescaler on the system clock; the divide ratio is a parameter. A 32-bit word-wide register port, with valid, write-enable, byte address and data signals, covers a 256-byte window. Software programs the period and starts the timer. It then reads the live count to measure elapsed time.

Three registers are mapped. Offset 0x00 holds a 32-bit control word. Bit 0 starts the counter and bit 31 requests a full timer reset. Offset 0x08 holds the 16-bit period. Offset 0x0C returns the live count. Once started, the counter runs until a control reset or a system reset. Writing a new period also loads it into the live count straight away.

Top module: `reload_timer16`

## Requirements
- R1: After system reset (rst_n low, then two clock edges after release), the control, period and count registers all read 0 and the counter is stopped.
- R2: A write to offset 0x00 with bit 31 set stops the counter and clears control, period and count to zero. The written word is not stored, so bit 0 in the same write does not start the counter.
- R3: A write to offset 0x00 with bit 31 clear stores all 32 written bits, which read back unchanged. If bit 0 is set, the counter starts.
- R4: A write to offset 0x08 keeps only bits 15:0 as the period. A read of 0x08 returns the period with bits 31:16 zero.
- R5: A write to offset 0x08 loads the new period into the live count in the same cycle and restarts the prescaler phase. This happens whether or not the counter is running.
- R6: While running, the count changes once every CLK_DIV clock cycles, with the first change CLK_DIV cycles after the start or period write. A nonzero count decrements by one. A count of zero reloads the period, and a period of zero keeps the count at zero.
- R7: A later control write with bit 0 clear (and bit 31 clear) does not stop a running counter.
- R8: A read of offset 0x0C returns the live count in bits 15:0 with bits 31:16 zero. Writes to 0x0C change nothing.
- R9: A read of any other offset, or of any address whose bits 1:0 are nonzero, returns 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the edge that accepts a read and held until the next read |

## Verification
The count readback is checked at points half a tick period away from each expected change. These include the first ticks after a start, the wrap from zero back to the period, a period rewritten mid-run, and a zero period. Together they separate an off-by-one in the prescaler from an error in the wrap or load priority. Control writes use three patterns: plain data with the enable set, an enable-clear write during a run, and a reset request that also carries the enable bit. These show whether the reset bit wins and whether the run state is sticky. Aligned unmapped offsets, misaligned addresses and writes to the count register confirm that the decode does not alias.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PERIOD = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h0C;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 31;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PERIOD,
    SEL_COUNT
  } tmr_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CLK_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

      logic [DW-1:0] div_q, div_d;
      logic          at_last;

      assign at_last = (div_q == LAST);

      always_comb begin
        div_d = div_q;
        if (!run || restart)  div_d = '0;
        else if (at_last)     div_d = '0;
        else                  div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = run && at_last;

      AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);  // R6
      AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || restart) |=> (div_q == '0));  // R5
    end
  endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] period,
  input  logic          tick,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (load)     cnt_d = load_val;
    else if (tick) begin
      if (cnt_zero)    cnt_d = period;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == $past(load_val)));  // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !clr && count == '0) |=> (count == $past(period)));  // R6
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !clr && count != '0) |=> (count == $past(count) - 1'b1));  // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr) |=> $stable(count));  // R6
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CW-1:0]     count,
  output logic              run,
  output logic              clr,
  output logic              load,
  output logic [CW-1:0]     load_val,
  output logic [CW-1:0]     period,
  output logic [BUS_W-1:0]  bus_rdata
);
  tmr_sel_e         sel;
  logic             wr_en, rd_en;
  logic [BUS_W-1:0] ctrl_q, ctrl_d;
  logic [CW-1:0]    per_q, per_d;
  logic             run_q, run_d;
  logic [BUS_W-1:0] rdata_q, rdata_d, rd_mux;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      unique case (bus_addr)
        OFF_CTRL:   sel = SEL_CTRL;
        OFF_PERIOD: sel = SEL_PERIOD;
        OFF_COUNT:  sel = SEL_COUNT;
        default:    sel = SEL_NONE;
      endcase
    end
  end

  assign wr_en    = bus_valid && bus_write;
  assign rd_en    = bus_valid && !bus_write;
  assign clr      = wr_en && (sel == SEL_CTRL) && bus_wdata[CTRL_CLR_BIT];
  assign load     = wr_en && (sel == SEL_PERIOD);
  assign load_val = bus_wdata[CW-1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    run_d  = run_q;
    if (clr) begin
      ctrl_d = '0;
      per_d  = '0;
      run_d  = 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) begin
        ctrl_d = bus_wdata;
        if (bus_wdata[CTRL_RUN_BIT]) run_d = 1'b1;
      end
      if (load) per_d = load_val;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_PERIOD: rd_mux = {{(BUS_W-CW){1'b0}}, per_q};
      SEL_COUNT:  rd_mux = {{(BUS_W-CW){1'b0}}, count};
      default:    rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      per_q   <= '0;
      run_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      per_q   <= per_d;
      run_q   <= run_d;
      rdata_q <= rdata_d;
    end
  end

  assign run       = run_q;
  assign period    = per_q;
  assign bus_rdata = rdata_q;

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctrl_q == '0 && period == '0 && !run));  // R2
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> run);  // R7
  AST_CNT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_COUNT) |=> (bus_rdata[BUS_W-1:CW] == '0));  // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (bus_rdata == '0));  // R9
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import tmr_pkg::*;
#(
  parameter int CLK_DIV = 250,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             run, clr, load, tick;
  logic [CNT_W-1:0] load_val, period, count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tmr_regs #(.CW(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .run       (run),
    .clr       (clr),
    .load      (load),
    .load_val  (load_val),
    .period    (period),
    .bus_rdata (bus_rdata)
  );

  tmr_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run),
    .restart (load),
    .tick    (tick)
  );

  tmr_count #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (clr),
    .load     (load),
    .load_val (load_val),
    .period   (period),
    .tick     (tick),
    .count    (count)
  );

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |-> !tick);  // R2
endmodule

// File: tb/reload_timer16_test.sv
module reload_timer16_test;
  localparam int D = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  // reference model state, derived from the requirements
  bit          m_run = 1'b0;
  int          m_per = 0;
  int          m_base = 0;   // count value at reference edge
  int          m_ref = 0;    // edge that set phase

  reload_timer16 #(.CLK_DIV(D), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    e = cyc;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output int e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    e = cyc;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_count(input int er);
    int t;
    if (!m_run || er - 1 < m_ref) return 32'(m_base);
    t = (er - 1 - m_ref) / D;
    if (m_base == 0 && m_per == 0) return 32'h0;
    // loads always set base == period here
    return 32'(m_per - (t % (m_per + 1)));
  endfunction

  task automatic rd_count(input string req);
    logic [31:0] d; int e;
    bus_rd(8'h0C, d, e);
    chk(req, d, exp_count(e));
  endtask

  task automatic do_sysreset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_run = 1'b0; m_per = 0; m_base = 0; m_ref = 0;
  endtask

  task automatic set_period(input int p);
    int e;
    bus_wr(8'h08, 32'(p), e);
    m_per = p; m_base = p; m_ref = e;
  endtask

  task automatic start_run(input logic [31:0] cw);
    int e;
    bus_wr(8'h00, cw, e);
    if (!m_run) begin m_run = 1'b1; m_ref = e; end
  endtask

  // R1
  task automatic t_reset_state();
    logic [31:0] d; int e;
    bus_rd(8'h00, d, e); chk("R1 ctrl", d, 32'h0);
    bus_rd(8'h08, d, e); chk("R1 period", d, 32'h0);
    bus_rd(8'h0C, d, e); chk("R1 count", d, 32'h0);
  endtask

  // R9
  task automatic t_unmapped();
    logic [31:0] d; int e;
    bus_wr(8'h04, 32'hFFFF_FFFF, e);
    bus_wr(8'h09, 32'h0000_7777, e);
    bus_wr(8'h01, 32'h0000_0001, e);
    bus_rd(8'h04, d, e); chk("R9 read 0x04", d, 32'h0);
    bus_rd(8'hFC, d, e); chk("R9 read 0xFC", d, 32'h0);
    bus_wr(8'h08, 32'h0000_0009, e);
    m_per = 9; m_base = 9; m_ref = e;
    bus_rd(8'h0A, d, e); chk("R9 misaligned read", d, 32'h0);
    bus_rd(8'h00, d, e); chk("R9 ctrl untouched", d, 32'h0);
    bus_rd(8'h08, d, e); chk("R9 period untouched", d, 32'h9);
    repeat (2 * D) @(posedge clk);
    rd_count("R9 misaligned enable write did not start");
  endtask

  // R4 R5 R3 R6
  task automatic t_start_and_wrap();
    logic [31:0] d; int e;
    set_period(32'h1234_0005 & 32'hFFFF);
    bus_wr(8'h08, 32'h1234_0005, e);
    bus_rd(8'h08, d, e); chk("R4 period upper bits dropped", d, 32'h5);
    bus_rd(8'h0C, d, e); chk("R5 count loaded while stopped", d, 32'h5);
    start_run(32'h0000_0A01);
    bus_rd(8'h00, d, e); chk("R3 ctrl stored", d, 32'h0000_0A01);
    repeat (D / 2) @(posedge clk);
    rd_count("R6 before first tick");
    repeat (D) @(posedge clk);
    rd_count("R6 after one tick");
    repeat (4 * D) @(posedge clk);
    rd_count("R6 reaches zero");
    repeat (D) @(posedge clk);
    rd_count("R6 wrap reload");
    repeat (2 * D) @(posedge clk);
    rd_count("R6 periodic after wrap");
  endtask

  // R7 R8
  task automatic t_enable_clear_and_count_write();
    logic [31:0] d; int e;
    bus_wr(8'h00, 32'h0000_0000, e);
    bus_rd(8'h00, d, e); chk("R7 ctrl reads zero", d, 32'h0);
    repeat (D) @(posedge clk);
    rd_count("R7 still running a");
    repeat (D) @(posedge clk);
    rd_count("R7 still running b");
    bus_wr(8'h0C, 32'h0000_BEEF, e);
    bus_rd(8'h0C, d, e);
    chk("R8 count write ignored", d, exp_count(e));
    chk("R8 upper bits zero", {16'h0, d[31:16]}, 32'h0);
    bus_rd(8'h08, d, e); chk("R8 period unaffected", d, 32'(m_per));
  endtask

  // R5 R6
  task automatic t_reload_mid_run();
    set_period(40000);
    rd_count("R5 immediate load while running");
    repeat (3 * D + D / 2) @(posedge clk);
    rd_count("R5 new phase from period write");
    set_period(0);
    repeat (3 * D) @(posedge clk);
    rd_count("R6 zero period holds zero");
  endtask

  // R2
  task automatic t_ctrl_reset();
    logic [31:0] d; int e;
    set_period(7);
    repeat (2 * D) @(posedge clk);
    bus_wr(8'h00, 32'h8000_0001, e);
    m_run = 1'b0; m_per = 0; m_base = 0;
    bus_rd(8'h00, d, e); chk("R2 ctrl cleared", d, 32'h0);
    bus_rd(8'h08, d, e); chk("R2 period cleared", d, 32'h0);
    bus_rd(8'h0C, d, e); chk("R2 count cleared", d, 32'h0);
    set_period(3);
    repeat (3 * D) @(posedge clk);
    rd_count("R2 counter stopped");
  endtask

  // R1
  task automatic t_sysreset_mid_run();
    set_period(20);
    start_run(32'h1);
    repeat (2 * D) @(posedge clk);
    do_sysreset();
    t_reset_state();
    repeat (2 * D) @(posedge clk);
    rd_count("R1 stopped after reset");
  endtask

  initial begin
    do_sysreset();
    t_reset_state();
    t_unmapped();
    t_start_and_wrap();
    t_enable_clear_and_count_write();
    t_reload_mid_run();
    t_ctrl_reset();
    t_sysreset_mid_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule